// File: doc/BRIEF.md
# Secure Session Privilege Tracker

This block keeps the security state of one host session with a secure memory. It records three things: the communication mode (standard, authenticated or encrypted), the single password that is currently in force together with its read or write grant, and a consecutive-failure counter for every key set and every password set. Neighbouring logic does the cryptography and MAC arithmetic. That logic sends the block one-cycle result pulses. From these pulses and its stored state, the block works out read and write permission for each of eight zones, checked against a configuration word per zone. It also raises a command-abort flag when an incoming MAC is rejected while a privileged mode is active.

The block acts on results only. A verification counts as a success when the neighbour reports a match and the credential has not been locked out. Any verification that is not a success, including a correct value presented to a locked credential, is a failure. A failure removes the state that the verification would have set up.

Top module: `sess_priv_tracker`

## Requirements
- R1: When `rst_n` is sampled low, the block returns to standard mode (`mode_o` = 0) with no password, no authentication and every trial counter at zero. Only zones that need nothing are granted, and `cmd_abort_o` is low.
- R2: A successful authentication with key set k selects authenticated mode (`mode_o` = 1) and records k. While authenticated, an encryption request naming the recorded key set selects encrypted mode (`mode_o` = 2). An encryption request made in standard mode has no effect.
- R3: A failed authentication discards any earlier authentication or encryption and returns the session to standard mode. Only the most recent request counts.
- R4: Only one password is held at a time. A successful verification replaces the held password. A failed verification leaves none held. Password verification never changes the mode.
- R5: A held write password for set s grants both read and write to zones that need set s. A held read password grants read only. Write permission is never granted without read permission.
- R6: A MAC mismatch reported in authenticated or encrypted mode abandons the command. `cmd_abort_o` is high for exactly one cycle, and the session returns to standard mode. A mismatch reported in standard mode changes nothing.
- R7: Each zone has an 8-bit configuration field at `zone_cfg_i[8z+7:8z]`. Bit 0 means a password is needed. Bits 3:1 give the password set. Bit 4 means authentication is needed. Bits 6:5 give the key set. Bit 7 means encryption is needed. A zone with a requirement is granted only when the held password set or key set matches.
- R8: After `TRIAL_LIMIT` (default 4) consecutive failures of one credential, every later verification of that credential fails, even when the neighbour reports a match.
- R9: A success before the limit is reached clears that credential's failure count, so a full `TRIAL_LIMIT - 1` further failures are again tolerated.
- R10: A zone that needs encryption is granted only in encrypted mode with the matching key set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all session state |
| auth_done_i | input | 1 | Pulse: an authentication result is reported |
| auth_match_i | input | 1 | Authentication compare matched |
| auth_key_i | input | 2 | Key set used for the authentication |
| enc_req_i | input | 1 | Pulse: encryption activation request |
| enc_key_i | input | 2 | Key set named by the encryption request |
| pw_done_i | input | 1 | Pulse: a password verification result is reported |
| pw_match_i | input | 1 | Password compare matched |
| pw_set_i | input | 3 | Password set presented |
| pw_is_write_i | input | 1 | 1 = write password, 0 = read password |
| mac_done_i | input | 1 | Pulse: a MAC check result is reported |
| mac_ok_i | input | 1 | MAC matched |
| zone_cfg_i | input | 64 | Per-zone requirement fields, 8 bits per zone |
| mode_o | output | 2 | 0 standard, 1 authenticated, 2 encrypted |
| zone_rd_o | output | 8 | Read permission per zone |
| zone_wr_o | output | 8 | Write permission per zone |
| cmd_abort_o | output | 1 | One-cycle flag: command abandoned on MAC mismatch |

## Verification
A result pulse is captured on one rising edge. The mode, the held password and the counters are registered, so `mode_o`, `zone_rd_o` and `zone_wr_o` show the new state from that edge on: one cycle after the pulse. `cmd_abort_o` is registered too. It is high for the single cycle after the edge that sampled the mismatch and low in the cycle after that. The bench drives every pulse on a falling edge for one cycle and samples at the next falling edge. This lands half a period after the capturing edge. For the abort flag, it checks one further falling edge to confirm that the flag has dropped.

// File: rtl/sess_pkg.sv
// Shared types for the session privilege tracker.
// Assumes a two-bit mode code that neighbours decode as 0/1/2.
package sess_pkg;
    typedef enum logic [1:0] {
        MODE_STD  = 2'd0,
        MODE_AUTH = 2'd1,
        MODE_ENC  = 2'd2
    } mode_t;
endpackage

// File: rtl/sess_trial_ctr.sv
// Consecutive-failure counter for one credential.
// A try in the same cycle as pass_i is a success only while unlocked.
// Success clears the count; failure raises it, saturating at the counter maximum.
// Assumes try_i is a one-cycle pulse.
module sess_trial_ctr #(
    parameter int CNT_W = 4,
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic try_i,
    input  logic pass_i,
    output logic grant_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] fail_cnt;
    logic             locked;

    // lockout once the failure count reaches the limit
    assign locked  = (fail_cnt >= CNT_LIM);
    assign grant_o = try_i && pass_i && !locked;

    // count consecutive failures; clear on success
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_cnt <= '0;
        end else if (try_i) begin
            if (grant_o)
                fail_cnt <= '0;
            else if (fail_cnt != CNT_MAX)
                fail_cnt <= fail_cnt + 1'b1;
        end
    end

    AST_PASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (try_i && pass_i && fail_cnt < CNT_LIM) |=> (fail_cnt == '0)); // R9

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt >= CNT_LIM) |=> (fail_cnt >= CNT_LIM)); // R8

    AST_FAIL_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (try_i && !pass_i && fail_cnt < CNT_LIM) |=> (fail_cnt == $past(fail_cnt) + 1'b1)); // R8
endmodule

// File: rtl/sess_state.sv
// Session state register: mode, recorded key set, held password and abort flag.
// Inputs are qualified results (lockout already applied by the counters).
// Ordering within a cycle: password and authentication/encryption are
// independent; a MAC mismatch in a privileged mode overrides the mode update.
module sess_state
    import sess_pkg::*;
#(
    parameter int KEY_W = 2,
    parameter int SET_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auth_done_i,
    input  logic             auth_pass_i,
    input  logic [KEY_W-1:0] auth_key_i,
    input  logic             enc_req_i,
    input  logic [KEY_W-1:0] enc_key_i,
    input  logic             pw_done_i,
    input  logic             pw_pass_i,
    input  logic [SET_W-1:0] pw_set_i,
    input  logic             pw_is_write_i,
    input  logic             mac_done_i,
    input  logic             mac_ok_i,
    output mode_t            mode_o,
    output logic [KEY_W-1:0] key_o,
    output logic             pw_valid_o,
    output logic [SET_W-1:0] pw_set_o,
    output logic             pw_write_o,
    output logic             abort_o
);
    mode_t            mode_q;
    logic [KEY_W-1:0] key_q;
    logic             pw_valid_q;
    logic [SET_W-1:0] pw_set_q;
    logic             pw_write_q;
    logic             abort_q;
    logic             mac_bad;

    // a mismatch counts only while a privilege is held
    assign mac_bad = mac_done_i && !mac_ok_i && (mode_q != MODE_STD);

    // hold the single active password
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_valid_q <= 1'b0;
            pw_set_q   <= '0;
            pw_write_q <= 1'b0;
        end else if (pw_done_i) begin
            pw_valid_q <= pw_pass_i;
            if (pw_pass_i) begin
                pw_set_q   <= pw_set_i;
                pw_write_q <= pw_is_write_i;
            end
        end
    end

    // mode and key set, with MAC revocation taking precedence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_STD;
            key_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= mac_bad;
            if (mac_bad) begin
                mode_q <= MODE_STD;
            end else if (auth_done_i) begin
                if (auth_pass_i) begin
                    mode_q <= MODE_AUTH;
                    key_q  <= auth_key_i;
                end else begin
                    mode_q <= MODE_STD;
                end
            end else if (enc_req_i && mode_q != MODE_STD && enc_key_i == key_q) begin
                mode_q <= MODE_ENC;
            end
        end
    end

    assign mode_o     = mode_q;
    assign key_o      = key_q;
    assign pw_valid_o = pw_valid_q;
    assign pw_set_o   = pw_set_q;
    assign pw_write_o = pw_write_q;
    assign abort_o    = abort_q;

    AST_ENC_FROM_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ENC && $past(mode_q) != MODE_ENC) |-> ($past(mode_q) == MODE_AUTH)); // R2

    AST_AUTH_FAIL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_done_i && !auth_pass_i) |=> (mode_q == MODE_STD)); // R3

    AST_MAC_REVOKES: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_done_i && !mac_ok_i && mode_q != MODE_STD) |=> (mode_q == MODE_STD && abort_q)); // R6

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |=> !abort_q); // R6

    AST_PW_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_done_i && !auth_done_i && !enc_req_i && !mac_done_i) |=> $stable(mode_q)); // R4
endmodule

// File: rtl/sess_zone_perm.sv
// Permission decode for one zone from its requirement field and the session state.
// Field layout: [0] needs password, [SET_W:1] set, [SET_W+1] needs auth,
// [SET_W+2 +: KEY_W] key set, [top] needs encryption. Purely combinational.
module sess_zone_perm
    import sess_pkg::*;
#(
    parameter int KEY_W = 2,
    parameter int SET_W = 3,
    localparam int CFG_W = SET_W + KEY_W + 3
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  mode_t            mode_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             pw_valid_i,
    input  logic [SET_W-1:0] pw_set_i,
    input  logic             pw_write_i,
    output logic             rd_o,
    output logic             wr_o
);
    logic             need_pw, need_auth, need_enc;
    logic [SET_W-1:0] want_set;
    logic [KEY_W-1:0] want_key;
    logic             pw_rd_ok, pw_wr_ok, auth_ok, enc_ok;

    assign need_pw   = cfg_i[0];
    assign want_set  = cfg_i[SET_W:1];
    assign need_auth = cfg_i[SET_W+1];
    assign want_key  = cfg_i[SET_W+2 +: KEY_W];
    assign need_enc  = cfg_i[CFG_W-1];

    // combine the password, authentication and encryption conditions
    always_comb begin
        pw_rd_ok = !need_pw || (pw_valid_i && pw_set_i == want_set);
        pw_wr_ok = !need_pw || (pw_valid_i && pw_set_i == want_set && pw_write_i);
        auth_ok  = !need_auth || (mode_i != MODE_STD && key_i == want_key);
        enc_ok   = !need_enc || (mode_i == MODE_ENC && key_i == want_key);
        rd_o     = pw_rd_ok && auth_ok && enc_ok;
        wr_o     = pw_wr_ok && auth_ok && enc_ok;
    end
endmodule

// File: rtl/sess_priv_tracker.sv
// Top of the session privilege tracker. Routes result pulses through one
// failure counter per key set and per password set, keeps the session state,
// and decodes per-zone permissions. Assumes at most one pulse of each kind per
// cycle and a zone configuration that is stable while used.
module sess_priv_tracker
    import sess_pkg::*;
#(
    parameter int N_ZONES     = 8,
    parameter int N_PWSETS    = 8,
    parameter int N_KEYSETS   = 4,
    parameter int CNT_W       = 4,
    parameter int TRIAL_LIMIT = 4,
    localparam int SET_W = $clog2(N_PWSETS),
    localparam int KEY_W = $clog2(N_KEYSETS),
    localparam int CFG_W = SET_W + KEY_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     auth_done_i,
    input  logic                     auth_match_i,
    input  logic [KEY_W-1:0]         auth_key_i,
    input  logic                     enc_req_i,
    input  logic [KEY_W-1:0]         enc_key_i,
    input  logic                     pw_done_i,
    input  logic                     pw_match_i,
    input  logic [SET_W-1:0]         pw_set_i,
    input  logic                     pw_is_write_i,
    input  logic                     mac_done_i,
    input  logic                     mac_ok_i,
    input  logic [N_ZONES*CFG_W-1:0] zone_cfg_i,
    output logic [1:0]               mode_o,
    output logic [N_ZONES-1:0]       zone_rd_o,
    output logic [N_ZONES-1:0]       zone_wr_o,
    output logic                     cmd_abort_o
);
    logic [N_KEYSETS-1:0] key_grant;
    logic [N_PWSETS-1:0]  pw_grant;
    mode_t                mode_s;
    logic [KEY_W-1:0]     key_s;
    logic                 pw_valid_s, pw_write_s, abort_s;
    logic [SET_W-1:0]     pw_set_s;

    // one failure counter per key set
    for (genvar k = 0; k < N_KEYSETS; k++) begin : g_key
        sess_trial_ctr #(.CNT_W(CNT_W), .LIMIT(TRIAL_LIMIT)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .try_i  (auth_done_i && auth_key_i == KEY_W'(k)),
            .pass_i (auth_match_i),
            .grant_o(key_grant[k])
        );
    end

    // one failure counter per password set
    for (genvar p = 0; p < N_PWSETS; p++) begin : g_pw
        sess_trial_ctr #(.CNT_W(CNT_W), .LIMIT(TRIAL_LIMIT)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .try_i  (pw_done_i && pw_set_i == SET_W'(p)),
            .pass_i (pw_match_i),
            .grant_o(pw_grant[p])
        );
    end

    sess_state #(.KEY_W(KEY_W), .SET_W(SET_W)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .auth_done_i  (auth_done_i),
        .auth_pass_i  (|key_grant),
        .auth_key_i   (auth_key_i),
        .enc_req_i    (enc_req_i),
        .enc_key_i    (enc_key_i),
        .pw_done_i    (pw_done_i),
        .pw_pass_i    (|pw_grant),
        .pw_set_i     (pw_set_i),
        .pw_is_write_i(pw_is_write_i),
        .mac_done_i   (mac_done_i),
        .mac_ok_i     (mac_ok_i),
        .mode_o       (mode_s),
        .key_o        (key_s),
        .pw_valid_o   (pw_valid_s),
        .pw_set_o     (pw_set_s),
        .pw_write_o   (pw_write_s),
        .abort_o      (abort_s)
    );

    // per-zone permission decode
    for (genvar z = 0; z < N_ZONES; z++) begin : g_zone
        sess_zone_perm #(.KEY_W(KEY_W), .SET_W(SET_W)) u_perm (
            .cfg_i     (zone_cfg_i[z*CFG_W +: CFG_W]),
            .mode_i    (mode_s),
            .key_i     (key_s),
            .pw_valid_i(pw_valid_s),
            .pw_set_i  (pw_set_s),
            .pw_write_i(pw_write_s),
            .rd_o      (zone_rd_o[z]),
            .wr_o      (zone_wr_o[z])
        );
    end

    assign mode_o      = mode_s;
    assign cmd_abort_o = abort_s;

    AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        ((zone_wr_o & ~zone_rd_o) == '0)); // R5

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd3)); // R2

    AST_RESET_STD: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 2'd0 && !cmd_abort_o)); // R1
endmodule

// File: tb/sess_priv_tracker_bench.sv
module sess_priv_tracker_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auth_done = 0, auth_match = 0, enc_req = 0;
    logic [1:0]  auth_key = 0, enc_key = 0;
    logic        pw_done = 0, pw_match = 0, pw_is_write = 0;
    logic [2:0]  pw_set = 0;
    logic        mac_done = 0, mac_ok = 0;
    logic [63:0] zone_cfg;
    logic [1:0]  mode;
    logic [7:0]  zone_rd, zone_wr;
    logic        cmd_abort;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #(CLK_P/2) clk = ~clk;

    // field: [0] need pw, [3:1] set, [4] need auth, [6:5] key, [7] need enc (R7)
    function automatic logic [7:0] zc(bit enc, logic [1:0] key, bit au, logic [2:0] st, bit pw);
        return {enc, key, au, st, pw};
    endfunction

    assign zone_cfg = {zc(1,2,0,0,0), zc(0,1,1,2,1), zc(1,1,1,0,0), zc(0,3,1,0,0),
                       zc(0,1,1,0,0), zc(0,0,0,5,1), zc(0,0,0,2,1), zc(0,0,0,0,0)};

    sess_priv_tracker u_sess_priv_tracker (
        .clk(clk), .rst_n(rst_n),
        .auth_done_i(auth_done), .auth_match_i(auth_match), .auth_key_i(auth_key),
        .enc_req_i(enc_req), .enc_key_i(enc_key),
        .pw_done_i(pw_done), .pw_match_i(pw_match), .pw_set_i(pw_set), .pw_is_write_i(pw_is_write),
        .mac_done_i(mac_done), .mac_ok_i(mac_ok), .zone_cfg_i(zone_cfg),
        .mode_o(mode), .zone_rd_o(zone_rd), .zone_wr_o(zone_wr), .cmd_abort_o(cmd_abort)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // every pulse: driven on a falling edge, lasts one cycle, result sampled at the next falling edge
    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        @(negedge clk);
    endtask

    task automatic auth(bit ok, logic [1:0] k);
        auth_done = 1; auth_match = ok; auth_key = k;
        @(negedge clk); auth_done = 0; auth_match = 0;
    endtask

    task automatic enc(logic [1:0] k);
        enc_req = 1; enc_key = k;
        @(negedge clk); enc_req = 0;
    endtask

    task automatic pw(bit ok, logic [2:0] s, bit wr);
        pw_done = 1; pw_match = ok; pw_set = s; pw_is_write = wr;
        @(negedge clk); pw_done = 0; pw_match = 0;
    endtask

    task automatic mac(bit ok);
        mac_done = 1; mac_ok = ok;
        @(negedge clk); mac_done = 0; mac_ok = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "mode", mode, 0);
        chk("R1", "rd", zone_rd, 8'h01);
        chk("R1", "wr", zone_wr, 8'h01);
        chk("R1", "abort", cmd_abort, 0);
    endtask

    task automatic t_passwords();
        pw(1, 2, 0);
        chk("R5", "read pw rd", zone_rd, 8'h03);
        chk("R5", "read pw wr", zone_wr, 8'h01);
        pw(1, 2, 1);
        chk("R5", "write pw rd", zone_rd, 8'h03);
        chk("R5", "write pw wr", zone_wr, 8'h03);
        pw(1, 5, 1);
        chk("R4", "replace rd", zone_rd, 8'h05);
        chk("R4", "replace wr", zone_wr, 8'h05);
        pw(0, 5, 1);
        chk("R4", "failed pw rd", zone_rd, 8'h01);
        chk("R4", "mode unchanged", mode, 0);
    endtask

    task automatic t_modes();
        pw(1, 2, 1);
        enc(1);
        chk("R2", "enc without auth", mode, 0);
        auth(1, 1);
        chk("R2", "auth mode", mode, 1);
        chk("R7", "auth key1 rd", zone_rd, 8'h4B);
        chk("R10", "enc zone closed in auth", zone_rd[5], 0);
        enc(2);
        chk("R2", "enc wrong key", mode, 1);
        enc(1);
        chk("R2", "enc mode", mode, 2);
        chk("R10", "enc key1 rd", zone_rd, 8'h6B);
        chk("R10", "enc key1 wr", zone_wr, 8'h6B);
        mac(1);
        chk("R6", "good mac keeps", mode, 2);
        chk("R6", "good mac no abort", cmd_abort, 0);
        mac(0);
        chk("R6", "abort raised", cmd_abort, 1);
        chk("R6", "revoked mode", mode, 0);
        chk("R6", "revoked rd", zone_rd, 8'h03);
        @(negedge clk);
        chk("R6", "abort one cycle", cmd_abort, 0);
        mac(0);
        chk("R6", "std mac no abort", cmd_abort, 0);
        chk("R6", "std mac mode", mode, 0);
        chk("R6", "std mac keeps pw", zone_rd, 8'h03);
    endtask

    task automatic t_reauth();
        auth(1, 3);
        chk("R7", "key3 rd", zone_rd, 8'h13);
        auth(0, 3);
        chk("R3", "fail clears", mode, 0);
        chk("R3", "fail rd", zone_rd, 8'h03);
        auth(1, 2);
        enc(2);
        chk("R10", "enc key2 rd", zone_rd, 8'h83);
        auth(0, 1);
        chk("R3", "fail from enc", mode, 0);
        chk("R3", "fail from enc rd", zone_rd, 8'h03);
    endtask

    task automatic t_lockout();
        do_reset();
        for (int i = 0; i < 3; i++) pw(0, 5, 1);
        pw(1, 5, 1);
        chk("R9", "success before limit", zone_rd, 8'h05);
        for (int i = 0; i < 3; i++) pw(0, 5, 1);
        pw(1, 5, 1);
        chk("R9", "count was cleared", zone_wr, 8'h05);
        for (int i = 0; i < 4; i++) pw(0, 5, 1);
        pw(1, 5, 1);
        chk("R8", "pw locked rd", zone_rd, 8'h01);
        pw(1, 2, 1);
        chk("R8", "other set free", zone_rd, 8'h03);
        for (int i = 0; i < 4; i++) auth(0, 3);
        auth(1, 3);
        chk("R8", "key locked", mode, 0);
        auth(1, 1);
        chk("R8", "other key free", mode, 1);
    endtask

    initial begin
        t_reset();
        t_passwords();
        t_modes();
        t_reauth();
        t_lockout();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule